// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block is the part of an I2C master that ends a transfer. Software writes a stop request. The block accepts the request only in master mode, and only when no start request arrives in the same cycle. It holds the request until the byte engine reaches a legal wait window. It then takes control of the open-drain SCL and SDA pull-down enables and plays out the stop sequence. First it holds both lines low. Next it lets SCL go and waits until SCL is sensed high, which allows a slave to stretch the clock. After a setup interval it lets SDA rise.

A stop detector watches the bus through two-flop synchronisers. It flags any stop, whether this block made it or another master did. The pending or running request is dropped when a stop is detected, when arbitration is lost, on a release command, or when the interface is disabled. A small transmit-direction flag is cleared when a wait ends at the ninth clock, so that the data line is left undriven.

The sequencer walks six named states. IDLE goes to PEND when a request is accepted. PEND goes to HOLD when the wait window is legal. HOLD goes to SCLREL after `HOLD_CYC` cycles. SCLREL goes to SETUP when the synchronised SCL is high. SETUP goes to SDAREL after `SETUP_CYC` cycles. SDAREL goes to IDLE on the detected stop. Every state goes to IDLE on a clear event.

Top module: `i2c_stop_gen`

## Requirements
- R1: While `scl_pull` is released at the end of HOLD, `sda_pull` stays asserted. `sda_pull` is released during a sequence only while the SCL line is high.
- R2: At least `SETUP_CYC` cycles pass with the SCL line high and `sda_pull` asserted before SDA is released. A slave holding SCL low delays this without breaking the sequence.
- R3: A stop write while `master_mode`=0 leaves `stop_busy` at 0 and the pulls released.
- R4: A stop write in the same cycle as `wr_start`=1 is ignored.
- R5: An accepted request only sets `stop_busy`. Nothing is driven until a legal window: `in_wait`=1, `ack_phase`=0 and `bit_cnt` equal to 9 if `wait_sel`=1 or 8 if `wait_sel`=0.
- R6: With `wait_sel`=0, a request made in the wait after the eighth clock produces the full sequence. Releasing SCL then forms the ninth clock, and the stop is made during its high phase.
- R7: `arb_lost`=1, `release_cmd`=1 or `ena`=0 returns `stop_busy` and both pulls to 0 at the next edge.
- R8: `stop_det` pulses when the synchronised SDA rises while the synchronised SCL is high. That pulse clears `stop_busy`, whether the stop was made here or elsewhere on the bus.
- R9: `trc` is set by `trc_set`. It falls at the edge after `wait_release`=1 with `in_wait`=1 and `bit_cnt`=9. A release at any other count leaves it at 1.
- R10: After reset, `stop_busy`, `scl_pull`, `sda_pull`, `stop_det` and `trc` are all 0.
- R11: In a sequence, `scl_pull` and `sda_pull` are both asserted for exactly `HOLD_CYC` cycles before SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ena | input | 1 | Interface enable; 0 clears the request |
| master_mode | input | 1 | 1 when the interface is bus master |
| wait_sel | input | 1 | 0: wait after clock 8, 1: wait after clock 9 |
| wr_stop | input | 1 | Stop-request write strobe |
| wr_start | input | 1 | Start-request write strobe |
| release_cmd | input | 1 | Exit-from-communication command |
| arb_lost | input | 1 | Arbitration-loss pulse from the shifter |
| wait_release | input | 1 | Wait-cancel strobe |
| trc_set | input | 1 | Sets the transmit-direction flag |
| bit_cnt | input | BIT_CNT_W | Clocks output in the current byte |
| in_wait | input | 1 | Shifter is in a wait period |
| ack_phase | input | 1 | Acknowledge bit period |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_pull | output | 1 | Drive SCL low when 1 |
| sda_pull | output | 1 | Drive SDA low when 1 |
| stop_busy | output | 1 | Stop request pending or running |
| stop_det | output | 1 | One-cycle stop-detected pulse |
| trc | output | 1 | Transmit-direction flag |

## Verification
The assertions assume that the strobes and shifter status are clean synchronous levels. They also assume that `scl_in` and `sda_in` are the wired-AND of this block's pulls and the other bus agents. They further assume that no other agent holds SCL low at the moment SDA is released. The stimulus models the lines as the AND of the block's pulls and the bench's own pull-downs. It holds SCL low during waits and lets go of it only once `scl_pull` is asserted. It stretches SCL only before the setup count starts. The random part draws mode and start-collision values and picks among clear events and complete stops. It draws nothing that would drive a line high or violate the wait framing.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_HOLD,
        ST_SCLREL,
        ST_SETUP,
        ST_SDAREL
    } stop_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic stop_seen
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              sda_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q[i] <= 1'b1;
                    sda_q[i] <= 1'b1;
                end else begin
                    scl_q[i] <= (i == 0) ? scl_in : scl_q[(i == 0) ? 0 : i-1];
                    sda_q[i] <= (i == 0) ? sda_in : sda_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_d <= 1'b1;
        else        sda_d <= sda_q[STAGES-1];
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign stop_seen = scl_s && sda_s && !sda_d;
endmodule

// File: rtl/i2c_stop_accept.sv
module i2c_stop_accept #(
    parameter int BIT_CNT_W = 4
) (
    input  logic                 wr_stop,
    input  logic                 wr_start,
    input  logic                 master_mode,
    input  logic                 ena,
    input  logic                 wait_sel,
    input  logic [BIT_CNT_W-1:0] bit_cnt,
    input  logic                 in_wait,
    input  logic                 ack_phase,
    output logic                 accept,
    output logic                 window_ok
);
    localparam logic [BIT_CNT_W-1:0] CNT_EIGHT = BIT_CNT_W'(8);
    localparam logic [BIT_CNT_W-1:0] CNT_NINE  = BIT_CNT_W'(9);

    logic [BIT_CNT_W-1:0] wait_cnt;

    always_comb begin
        wait_cnt  = wait_sel ? CNT_NINE : CNT_EIGHT;
        accept    = wr_stop && !wr_start && master_mode && ena;
        window_ok = in_wait && !ack_phase && (bit_cnt == wait_cnt);
    end
endmodule

// File: rtl/i2c_trc_flag.sv
module i2c_trc_flag #(
    parameter int BIT_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trc_set,
    input  logic                 drop,
    input  logic                 wait_release,
    input  logic                 in_wait,
    input  logic [BIT_CNT_W-1:0] bit_cnt,
    output logic                 trc
);
    localparam logic [BIT_CNT_W-1:0] CNT_NINE = BIT_CNT_W'(9);

    logic ninth_release;
    assign ninth_release = wait_release && in_wait && (bit_cnt == CNT_NINE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     trc <= 1'b0;
        else if (drop || ninth_release) trc <= 1'b0;
        else if (trc_set)               trc <= 1'b1;
    end
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
    import i2c_stop_pkg::*;
#(
    parameter int HOLD_CYC  = 4,
    parameter int SETUP_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic window_ok,
    input  logic clear,
    input  logic scl_s,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy
);
    localparam int MAX_CYC = (HOLD_CYC > SETUP_CYC) ? HOLD_CYC : SETUP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);

    stop_state_t state, nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       cnt <= '0;
        else if (state != nxt)                            cnt <= '0;
        else if (state == ST_HOLD || state == ST_SETUP)   cnt <= cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept)             nxt = ST_PEND;
            ST_PEND:   if (window_ok)          nxt = ST_HOLD;
            ST_HOLD:   if (cnt == HOLD_LAST)   nxt = ST_SCLREL;
            ST_SCLREL: if (scl_s)              nxt = ST_SETUP;
            ST_SETUP:  if (cnt == SETUP_LAST)  nxt = ST_SDAREL;
            ST_SDAREL:                         nxt = ST_SDAREL;
            default:                           nxt = ST_IDLE;
        endcase
        if (clear) nxt = ST_IDLE;
    end

    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_PEND:   ;
            ST_HOLD:   begin scl_pull = 1'b1; sda_pull = 1'b1; end
            ST_SCLREL: sda_pull = 1'b1;
            ST_SETUP:  sda_pull = 1'b1;
            ST_SDAREL: ;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen #(
    parameter int BIT_CNT_W = 4,
    parameter int HOLD_CYC  = 4,
    parameter int SETUP_CYC = 5,
    parameter int SYNC_STG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ena,
    input  logic                 master_mode,
    input  logic                 wait_sel,
    input  logic                 wr_stop,
    input  logic                 wr_start,
    input  logic                 release_cmd,
    input  logic                 arb_lost,
    input  logic                 wait_release,
    input  logic                 trc_set,
    input  logic [BIT_CNT_W-1:0] bit_cnt,
    input  logic                 in_wait,
    input  logic                 ack_phase,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 scl_pull,
    output logic                 sda_pull,
    output logic                 stop_busy,
    output logic                 stop_det,
    output logic                 trc
);
    logic scl_s, sda_s, accept, window_ok, clear;

    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .stop_seen(stop_det)
    );

    i2c_stop_accept #(.BIT_CNT_W(BIT_CNT_W)) u_acc (
        .wr_stop(wr_stop), .wr_start(wr_start), .master_mode(master_mode),
        .ena(ena), .wait_sel(wait_sel), .bit_cnt(bit_cnt), .in_wait(in_wait),
        .ack_phase(ack_phase), .accept(accept), .window_ok(window_ok)
    );

    assign clear = stop_det || arb_lost || release_cmd || !ena;

    i2c_stop_seq #(.HOLD_CYC(HOLD_CYC), .SETUP_CYC(SETUP_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .window_ok(window_ok),
        .clear(clear), .scl_s(scl_s), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .busy(stop_busy)
    );

    i2c_trc_flag #(.BIT_CNT_W(BIT_CNT_W)) u_trc (
        .clk(clk), .rst_n(rst_n), .trc_set(trc_set),
        .drop(release_cmd || !ena), .wait_release(wait_release),
        .in_wait(in_wait), .bit_cnt(bit_cnt), .trc(trc)
    );
endmodule

// File: rtl/i2c_stop_chk.sv
module i2c_stop_chk #(
    parameter int BIT_CNT_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ena,
    input logic                 master_mode,
    input logic                 wr_stop,
    input logic                 wr_start,
    input logic                 release_cmd,
    input logic                 arb_lost,
    input logic                 wait_release,
    input logic [BIT_CNT_W-1:0] bit_cnt,
    input logic                 in_wait,
    input logic                 ack_phase,
    input logic                 scl_in,
    input logic                 scl_pull,
    input logic                 sda_pull,
    input logic                 stop_busy,
    input logic                 trc
);
    assert_sda_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_pull) && stop_busy) |-> sda_pull);

    assert_sda_rise_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull) && stop_busy) |-> scl_in);

    assert_slave_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && wr_stop && !stop_busy) |=> !stop_busy);

    assert_start_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && wr_stop && !stop_busy) |=> !stop_busy);

    assert_legal_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(in_wait && !ack_phase));

    assert_clear_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost || release_cmd || !ena) |=> (!stop_busy && !sda_pull && !scl_pull));

    assert_trc_ninth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trc && wait_release && in_wait && bit_cnt == BIT_CNT_W'(9)) |=> !trc);
endmodule

bind i2c_stop_gen i2c_stop_chk #(.BIT_CNT_W(BIT_CNT_W)) u_chk (.*);

// File: tb/i2c_stop_gen_tb.sv
module i2c_stop_gen_tb;
    localparam int HOLD  = 4;
    localparam int SETUP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ena = 1'b1, master_mode = 1'b1, wait_sel = 1'b1;
    logic wr_stop = 1'b0, wr_start = 1'b0, release_cmd = 1'b0, arb_lost = 1'b0;
    logic wait_release = 1'b0, trc_set = 1'b0, in_wait = 1'b0, ack_phase = 1'b0;
    logic [3:0] bit_cnt = 4'd0;
    logic scl_ext = 1'b0, sda_ext = 1'b0;
    logic scl_pull, sda_pull, stop_busy, stop_det, trc;
    logic scl_line, sda_line;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = !(scl_pull || scl_ext);
    assign sda_line = !(sda_pull || sda_ext);

    i2c_stop_gen #(.HOLD_CYC(HOLD), .SETUP_CYC(SETUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ena(ena), .master_mode(master_mode),
        .wait_sel(wait_sel), .wr_stop(wr_stop), .wr_start(wr_start),
        .release_cmd(release_cmd), .arb_lost(arb_lost),
        .wait_release(wait_release), .trc_set(trc_set), .bit_cnt(bit_cnt),
        .in_wait(in_wait), .ack_phase(ack_phase), .scl_in(scl_line),
        .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .stop_busy(stop_busy), .stop_det(stop_det), .trc(trc)
    );

    function automatic bit exp_accept(bit m, bit st, bit en);
        return m && !st && en;
    endfunction

    function automatic logic [3:0] wait_count(bit ws);
        return ws ? 4'd9 : 4'd8;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic request(bit st);
        @(negedge clk);
        wr_stop = 1'b1; wr_start = st;
        @(negedge clk);
        wr_stop = 1'b0; wr_start = 1'b0;
    endtask

    task automatic open_window();
        in_wait = 1'b1; ack_phase = 1'b0; bit_cnt = wait_count(wait_sel);
        scl_ext = 1'b1;
    endtask

    task automatic close_window();
        in_wait = 1'b0; bit_cnt = 4'd0; scl_ext = 1'b0;
    endtask

    task automatic pulse_clear(int kind);
        @(negedge clk);
        if (kind == 0) arb_lost = 1'b1;
        else if (kind == 1) release_cmd = 1'b1;
        else ena = 1'b0;
        @(negedge clk);
        arb_lost = 1'b0; release_cmd = 1'b0; ena = 1'b1;
    endtask

    task automatic run_stop(int stretch);
        int guard = 0, hold_n = 0, setup_n = 0;
        bit seen_det = 1'b0;
        while (!scl_pull && guard < 10) begin @(negedge clk); guard++; end
        chk("R1 sda pulled with scl", int'(sda_pull), 1);
        scl_ext = 1'b0;
        while (scl_pull) begin
            hold_n++;
            if (!sda_pull) hold_n += 100;
            @(negedge clk);
        end
        chk("R11 hold cycles", hold_n, HOLD);
        if (stretch > 0) begin
            scl_ext = 1'b1;
            for (int i = 0; i < stretch; i++) begin
                @(negedge clk);
                chk("R2 sda held while stretched", int'(sda_pull), 1);
            end
            scl_ext = 1'b0;
        end
        guard = 0;
        while (sda_pull && guard < 40) begin
            if (scl_line) setup_n++;
            @(negedge clk);
            guard++;
        end
        chk("R2 setup at least SETUP", int'(setup_n >= SETUP && setup_n <= SETUP + 4), 1);
        chk("R1 scl high at sda release", int'(scl_line), 1);
        guard = 0;
        while (stop_busy && guard < 20) begin
            if (stop_det) seen_det = 1'b1;
            @(negedge clk);
            guard++;
        end
        if (stop_det) seen_det = 1'b1;
        chk("R8 own stop detected", int'(seen_det), 1);
        chk("R8 busy cleared by stop", int'(stop_busy), 0);
        close_window();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int kind;
        bit m, st, e;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 busy", int'(stop_busy), 0);
        chk("R10 pulls", int'(scl_pull || sda_pull), 0);
        chk("R10 trc", int'(trc), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 stop_det", int'(stop_det), 0);

        // R3 slave mode ignored
        master_mode = 1'b0; request(1'b0);
        chk("R3 busy", int'(stop_busy), 0);
        repeat (3) @(negedge clk);
        chk("R3 pulls", int'(scl_pull || sda_pull), 0);
        master_mode = 1'b1;

        // R4 start collision
        request(1'b1);
        chk("R4 busy", int'(stop_busy), 0);

        // R5 held during transfer, ack and wrong count
        request(1'b0);
        chk("R5 accepted", int'(stop_busy), 1);
        repeat (4) @(negedge clk);
        chk("R5 no drive in transfer", int'(sda_pull), 0);
        in_wait = 1'b1; ack_phase = 1'b1; bit_cnt = 4'd9; scl_ext = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 no drive in ack", int'(sda_pull), 0);
        ack_phase = 1'b0; bit_cnt = 4'd8;
        repeat (3) @(negedge clk);
        chk("R5 no drive at count 8 with wait_sel 1", int'(sda_pull), 0);
        bit_cnt = 4'd9;
        @(negedge clk);
        chk("R5 drive at legal window", int'(sda_pull), 1);
        run_stop(0);

        // R6 wait after eighth clock
        wait_sel = 1'b0;
        request(1'b0);
        open_window();
        run_stop(3);
        wait_sel = 1'b1;

        // R7 clear events
        for (int k = 0; k < 3; k++) begin
            request(1'b0);
            pulse_clear(k);
            chk("R7 cleared", int'(stop_busy), 0);
        end
        request(1'b0);
        open_window();
        repeat (2) @(negedge clk);
        pulse_clear(0);
        chk("R7 cleared mid sequence", int'(stop_busy || sda_pull || scl_pull), 0);
        close_window();

        // R8 foreign stop
        request(1'b0);
        sda_ext = 1'b1;
        repeat (4) @(negedge clk);
        sda_ext = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (stop_det) seen = 1'b1;
            end
            chk("R8 foreign stop pulse", int'(seen), 1);
        end
        chk("R8 foreign stop clears", int'(stop_busy), 0);

        // R9 transmit flag
        @(negedge clk); trc_set = 1'b1;
        @(negedge clk); trc_set = 1'b0;
        chk("R9 set", int'(trc), 1);
        in_wait = 1'b1; bit_cnt = 4'd8; wait_release = 1'b1;
        @(negedge clk); wait_release = 1'b0;
        chk("R9 kept at count 8", int'(trc), 1);
        bit_cnt = 4'd9; wait_release = 1'b1;
        @(negedge clk); wait_release = 1'b0;
        chk("R9 cleared at ninth", int'(trc), 0);
        close_window();

        // random mix (R3 R4 R7 R1 R2)
        for (int it = 0; it < 30; it++) begin
            m = 1'($urandom % 2); st = ($urandom % 4) == 0; e = 1'b1;
            master_mode = m;
            request(st);
            chk("R3/R4 random accept", int'(stop_busy), int'(exp_accept(m, st, e)));
            master_mode = 1'b1;
            if (stop_busy) begin
                kind = int'($urandom % 4);
                if (kind < 3) begin
                    pulse_clear(kind);
                    chk("R7 random clear", int'(stop_busy), 0);
                end else begin
                    wait_sel = 1'($urandom % 2);
                    open_window();
                    run_stop(int'($urandom % 3));
                end
            end
            repeat (2) @(negedge clk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule